// File: doc/BRIEF.md
# Dual sink/source current DAC controller

This block is a two-wire serial target that holds the settings of two current-output channels. It oversamples SCL and SDA with a fast system clock. From those samples it finds START, repeated START and STOP conditions. It accepts a write made of three bytes: the device address, the register pointer and the data. It also accepts a single-byte read, made of a pointer write, a repeated START, the read address and one data byte returned to the host.

Each channel register is eight bits in sign-magnitude form. The block decodes it into a 4-bit magnitude and two enables, one for sourcing and one for sinking. An analog current stage downstream turns these into a current. The block does not model that stage or its full-scale scaling.

The SDA pad is open-drain. `sda_oe_o` high pulls the line low, and `sda_oe_o` low releases it.

Top module: `i2c_cdac_ctrl`

## Requirements
- R1: The target acknowledges an address byte whose bits 7:1 equal 0x48. Bit 0 is R/W, so 0x90 starts a write and 0x91 starts a read.
- R2: Register 0xF8 drives channel 0 and register 0xF9 drives channel 1. A write to one channel leaves the other unchanged.
- R3: In a channel register, bits 3:0 appear on that channel's magnitude output. Bit 7 set to 1 selects source and bit 7 clear selects sink, and source and sink are never enabled together.
- R4: A magnitude of 0 clears both enables of that channel, whatever bit 7 holds.
- R5: After reset both registers are 0x00, all outputs are zero and SDA is released.
- R6: A write is address byte, then pointer, then data. The target pulls SDA low in the ninth clock of each of these three bytes.
- R7: After an address byte that does not match, the target neither drives SDA nor acts on any byte until the next START. A valid transfer after a repeated START is served normally.
- R8: SDA is sampled on the rising edge of SCL. The target changes SDA only while SCL is low, so read data is stable for the whole high phase.
- R9: A read returns the addressed register MSB first. After the host's NACK and STOP, SDA is released.
- R10: A pointer other than 0xF8 or 0xF9 is still acknowledged. Data written to it is discarded, and a read from it returns 0x00.
- R11: Bits 6:4 are stored as written and read back unchanged.
- R12: Channel outputs change only after the ACK clock of a data byte has ended. They do not change during that ACK clock, and they hold at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| mag_o | output | NCH*MAG_W | Magnitude per channel, channel 0 in the low bits |
| src_en_o | output | NCH | Source enable per channel |
| snk_en_o | output | NCH | Sink enable per channel |

## Verification
Two functions can fall in the same cycle here. The first is START detection: SDA falls while SCL is high, after the bit engine has already counted that SCL high phase's rising edge as a data bit. The second is the byte-level decision that rides on the same counter. The bench provokes this overlap with repeated STARTs. One follows a matched pointer write. The other follows a rejected foreign address, where the engine is parked and must wake only on the START. The test is judged by the ACK on the following address byte, and by the read data or the channel outputs that result. An off-by-one in that overlap shows up as a missing ACK or as a shifted byte.

// File: rtl/cdac_pkg.sv
package cdac_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX} bus_st_e;
  typedef enum logic [1:0] {BY_ADDR, BY_PTR, BY_DATA} byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge with SCL high on both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import cdac_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] ptr_o,
  output logic [7:0] wr_data_o,
  output bus_st_e    state_o
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

  bus_st_e        state;
  byte_kind_e     kind;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]     rx_sh, tx_sh, ptr;
  logic           rw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      kind     <= BY_ADDR;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      sda_oe_o <= 1'b0;
      wr_en_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state    <= ST_RX;
        kind     <= BY_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise_i) begin
              rx_sh   <= {rx_sh[6:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i && bit_cnt == BYTE_BITS) begin
              bit_cnt <= '0;
              if (kind == BY_ADDR && rx_sh[7:1] != DEV_ADDR) begin
                state <= ST_IDLE;            // foreign target: park until START
              end else begin
                if (kind == BY_ADDR) rw <= rx_sh[0];
                if (kind == BY_PTR)  ptr <= rx_sh;
                state    <= ST_ACK;
                sda_oe_o <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              unique case (kind)
                BY_ADDR: begin
                  if (rw) begin
                    state    <= ST_TX;
                    tx_sh    <= rd_data_i;
                    sda_oe_o <= ~rd_data_i[7];
                    bit_cnt  <= '0;
                  end else begin
                    state <= ST_RX;
                    kind  <= BY_PTR;
                  end
                end
                BY_PTR: begin
                  state <= ST_RX;
                  kind  <= BY_DATA;
                end
                default: begin
                  state   <= ST_IDLE;
                  wr_en_o <= 1'b1;           // commit after data ACK clock
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i) begin
              if (bit_cnt == BYTE_BITS) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
              end else begin
                tx_sh    <= {tx_sh[6:0], 1'b0};
                sda_oe_o <= ~tx_sh[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o     = ptr;
  assign wr_data_o = rx_sh;
  assign state_o   = state;
endmodule

// File: rtl/cdac_chan_regs.sv
module cdac_chan_regs #(
  parameter int         NCH       = 2,
  parameter int         MAG_W     = 4,
  parameter logic [7:0] BASE_ADDR = 8'hF8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [7:0]           addr_i,
  input  logic [7:0]           wr_data_i,
  output logic [7:0]           rd_data_o,
  output logic [NCH*MAG_W-1:0] mag_o,
  output logic [NCH-1:0]       src_en_o,
  output logic [NCH-1:0]       snk_en_o
);
  localparam int SIGN_BIT = 7;

  logic [7:0]     regs [NCH];
  logic [NCH-1:0] hit;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [7:0] CH_ADDR = 8'(int'(BASE_ADDR) + g);
    logic [MAG_W-1:0] mag;
    logic             nz;

    assign hit[g] = (addr_i == CH_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                regs[g] <= '0;
      else if (wr_en_i && hit[g]) regs[g] <= wr_data_i;
    end

    assign mag                      = regs[g][MAG_W-1:0];
    assign nz                       = |mag;
    assign mag_o[g*MAG_W +: MAG_W]  = mag;
    assign src_en_o[g]              = nz &  regs[g][SIGN_BIT];
    assign snk_en_o[g]              = nz & ~regs[g][SIGN_BIT];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NCH; i++)
      if (hit[i]) rd_data_o = regs[i];
  end
endmodule

// File: rtl/i2c_cdac_ctrl.sv
module i2c_cdac_ctrl
  import cdac_pkg::*;
#(
  parameter int         NCH       = 2,
  parameter int         MAG_W     = 4,
  parameter int         SYNC_STG  = 2,
  parameter logic [6:0] DEV_ADDR  = 7'h48,
  parameter logic [7:0] BASE_ADDR = 8'hF8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  output logic [NCH*MAG_W-1:0] mag_o,
  output logic [NCH-1:0]       src_en_o,
  output logic [NCH-1:0]       snk_en_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_en;
  logic [7:0] ptr, wr_data, rd_data;
  bus_st_e eng_st;

  i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop),
    .rd_data_i(rd_data), .sda_oe_o,
    .wr_en_o(wr_en), .ptr_o(ptr), .wr_data_o(wr_data), .state_o(eng_st)
  );

  cdac_chan_regs #(.NCH(NCH), .MAG_W(MAG_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .addr_i(ptr), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .mag_o, .src_en_o, .snk_en_o
  );
endmodule

// File: rtl/cdac_ctrl_chk.sv
module cdac_ctrl_chk
  import cdac_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int MAG_W = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 scl_s_i,
  input bus_st_e              st_i,
  input logic                 wr_en_i,
  input logic                 sda_oe_i,
  input logic [NCH*MAG_W-1:0] mag_i,
  input logic [NCH-1:0]       src_en_i,
  input logic [NCH-1:0]       snk_en_i
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    p_zero_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mag_i[g*MAG_W +: MAG_W] == '0) |-> (!src_en_i[g] && !snk_en_i[g]));
    p_dir_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(src_en_i[g] && snk_en_i[g]));
  end

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> ($stable(mag_i) && $stable(src_en_i) && $stable(snk_en_i)));

  p_drive_scl_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_s_i);

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !sda_oe_i);
endmodule

bind i2c_cdac_ctrl cdac_ctrl_chk #(.NCH(NCH), .MAG_W(MAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .st_i(eng_st),
  .wr_en_i(wr_en), .sda_oe_i(sda_oe_o), .mag_i(mag_o),
  .src_en_i(src_en_o), .snk_en_i(snk_en_o)
);

// File: tb/tb_i2c_cdac_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_cdac_ctrl;
  localparam int NCH = 2;
  localparam int MAG_W = 4;
  localparam int Q = 10;
  localparam int NVEC = 8;
  // {reg, data, exp_mag, exp_src, exp_snk}
  localparam logic [21:0] VEC [NVEC] = '{
    {8'hF8, 8'h8A, 4'hA, 1'b1, 1'b0},
    {8'hF9, 8'h05, 4'h5, 1'b0, 1'b1},
    {8'hF8, 8'h80, 4'h0, 1'b0, 1'b0},
    {8'hF9, 8'h0F, 4'hF, 1'b0, 1'b1},
    {8'hF8, 8'h70, 4'h0, 1'b0, 1'b0},
    {8'hF8, 8'hF3, 4'h3, 1'b1, 1'b0},
    {8'hF9, 8'h8F, 4'hF, 1'b1, 1'b0},
    {8'hF9, 8'h00, 4'h0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NCH*MAG_W-1:0] mag;
  logic [NCH-1:0] src_en, snk_en;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int failures = 0;
  int unstable = 0;
  logic [5:0] mid_out;
  logic [7:0] shadow [NCH];

  always #4 clk = ~clk;

  i2c_cdac_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .mag_o(mag), .src_en_o(src_en), .snk_en_o(snk_en)
  );

  function automatic logic [5:0] exp_of(input logic [7:0] r);
    logic nz = |r[3:0];
    return {r[3:0], nz & r[7], nz & ~r[7]};
  endfunction

  function automatic logic [5:0] out_of(input int ch);
    return {mag[ch*MAG_W +: MAG_W], src_en[ch], snk_en[ch]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl = 1'b1; q();
    ack = ~sda_line;
    mid_out = out_of(int'(shadow_ch));
    q(); scl = 1'b0; q();
  endtask

  int shadow_ch = 0;

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    logic s1, s2;
    b = '0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; q(); scl = 1'b1; s1 = sda_line; q(); q(); s2 = sda_line;
      if (s1 !== s2) unstable++;
      b = {b[6:0], s2};
      scl = 1'b0; q();
    end
    sda_m = nack; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
    logic k;
    bus_start();
    send_byte(8'h90, k); acks[2] = k;
    send_byte(a, k);     acks[1] = k;
    send_byte(d, k);     acks[0] = k;
    bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d, output logic [2:0] acks);
    logic k;
    bus_start();
    send_byte(8'h90, k); acks[2] = k;
    send_byte(a, k);     acks[1] = k;
    bus_rstart();
    send_byte(8'h91, k); acks[0] = k;
    recv_byte(d, 1'b1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] rd;
    logic ack;
    shadow[0] = 8'h00;
    shadow[1] = 8'h00;
    repeat (5) @(negedge clk);
    chk("R5 reset ch0", 32'(out_of(0)), 32'(6'h0));
    chk("R5 reset ch1", 32'(out_of(1)), 32'(6'h0));
    chk("R5 reset sda", 32'(sda_oe), 32'(0));
    rst_n = 1'b1;
    q();

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] ra, dd;
      int ch, oth;
      ra = VEC[v][21:14];
      dd = VEC[v][13:6];
      ch = int'(ra[0]);
      oth = 1 - ch;
      shadow_ch = ch;
      wr_reg(ra, dd, acks);
      shadow[ch] = dd;
      chk("R6 R1 write acks", 32'(acks), 32'(3'b111));
      chk("R2 R3 R4 target channel", 32'(out_of(ch)), 32'(VEC[v][5:0]));
      chk("R2 other channel held", 32'(out_of(oth)), 32'(exp_of(shadow[oth])));
      unstable = 0;
      rd_reg(ra, rd, acks);
      chk("R1 R9 read acks", 32'(acks), 32'(3'b111));
      chk("R9 R11 readback", 32'(rd), 32'(dd));
      chk("R8 sda stable while scl high", 32'(unstable), 32'(0));
      chk("R9 released after stop", 32'(sda_oe), 32'(0));
    end

    // R12: no change during data ACK clock, change after it
    shadow_ch = 1;
    wr_reg(8'hF9, 8'h83, acks);
    chk("R12 unchanged during ack", 32'(mid_out), 32'(exp_of(shadow[1])));
    shadow[1] = 8'h83;
    chk("R12 updated after ack", 32'(out_of(1)), 32'(exp_of(8'h83)));

    // R7: foreign address ignored until next START
    shadow_ch = 0;
    bus_start();
    send_byte(8'hA0, ack); chk("R7 no ack foreign addr", 32'(ack), 32'(0));
    send_byte(8'hF8, ack); chk("R7 no ack ptr", 32'(ack), 32'(0));
    send_byte(8'h85, ack); chk("R7 no ack data", 32'(ack), 32'(0));
    bus_stop();
    chk("R7 ch0 unchanged", 32'(out_of(0)), 32'(exp_of(shadow[0])));
    bus_start();
    send_byte(8'h92, ack); chk("R7 R1 no ack 0x92", 32'(ack), 32'(0));
    bus_rstart();
    send_byte(8'h90, ack); chk("R7 ack after rstart", 32'(ack), 32'(1));
    send_byte(8'hF8, ack);
    send_byte(8'h8C, ack); chk("R7 data ack after rstart", 32'(ack), 32'(1));
    bus_stop();
    shadow[0] = 8'h8C;
    chk("R7 write after rstart applied", 32'(out_of(0)), 32'(exp_of(8'h8C)));

    // R10: unmapped pointer
    wr_reg(8'h10, 8'hFF, acks);
    chk("R10 unmapped write acked", 32'(acks), 32'(3'b111));
    chk("R10 ch0 unchanged", 32'(out_of(0)), 32'(exp_of(shadow[0])));
    chk("R10 ch1 unchanged", 32'(out_of(1)), 32'(exp_of(shadow[1])));
    rd_reg(8'h10, rd, acks);
    chk("R10 unmapped read zero", 32'(rd), 32'(0));
    rd_reg(8'hFA, rd, acks);
    chk("R10 read 0xFA zero", 32'(rd), 32'(0));
    chk("R10 read acks", 32'(acks), 32'(3'b111));

    // R5: reset again mid-run
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 reset clears ch0", 32'(out_of(0)), 32'(0));
    chk("R5 reset clears ch1", 32'(out_of(1)), 32'(0));
    rst_n = 1'b1;
    q();
    rd_reg(8'hF8, rd, acks);
    chk("R5 reg zero after reset", 32'(rd), 32'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule